// File: doc/BRIEF.md
# Fractional 32-Step Clock-Enable Generator

This block turns a free-running input clock into a single-cycle enable stream. Its average rate is the input rate scaled by (32 − N)/32, where N is a 5-bit reduction code. Logic downstream qualifies its registers with the enable to run at the reduced rate without a second clock domain. A code of 0 keeps every cycle, and a code of 31 keeps one cycle in 32.

Software controls the block through a small word-addressed register port with two registers. The rate register holds a staged code in bits 12:8, and its remaining bits are plain storage. The kick register uses bit 31 as a handshake: writing 1 there asks the hardware to adopt the staged code. A three-state machine handles the request. IDLE becomes ARMED on an accepted kick. ARMED becomes SWITCH in the second-to-last cycle of a 32-cycle frame. SWITCH returns to IDLE at the frame edge, and on that edge the code taken at kick time becomes active. The kick bit reads 1 in ARMED and SWITCH and drops back to 0 once the new code drives the output, so software polls it to learn that the change is complete. A phase accumulator adds (32 − N) modulo 32 every cycle and fires the enable on each carry. Each frame therefore holds exactly 32 − N enables, spaced as evenly as the count allows.

Top module: `frac_ce_gen`

## Requirements
- R1: After reset the active code reads 0, the kick bit reads 0, and the enable is high on every cycle.
- R2: With active code N, any 32 consecutive cycles hold exactly 32 − N enable pulses.
- R3: Successive enable pulses are separated by either floor(32/(32−N)) or ceil(32/(32−N)) cycles.
- R4: A write to the rate register (word address 2) changes only the staged code. The code read back from bits 12:8 and the enable rate stay at the active value until a kick completes.
- R5: Writing a word with bit 31 set to the kick register (word address 1) while idle makes bit 31 of that register read 1.
- R6: The kick bit clears within 33 cycles of the kick write. From then on, bits 12:8 of the rate register read the kicked code and the enable rate follows it.
- R7: The active code changes only at a 32-cycle frame edge and never within a frame.
- R8: Rate writes made while a kick is pending leave the code being applied unchanged. The new value stays staged and takes effect at the next kick.
- R9: A kick write while a kick is pending, and a kick-register write with bit 31 clear, have no effect. Completion is still timed from the first accepted kick.
- R10: Bits of the rate register outside 12:8 read back as last written. Bits of the kick register other than 31 read 0, and any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Word address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ce | output | 1 | One-cycle clock-enable pulse |

## Verification
The bench steps through all 32 codes in a scrambled order, so each change crosses a different pair of old and new codes. For every code it checks both the pulse count per 32-cycle window and the spacing between pulses. The count alone would accept pulses bunched together, so the spacing check is what separates an accumulator that spreads pulses from one that does not. Rate writes made during an armed kick, repeated kicks, and writes with bit 31 clear show that the snapshot taken at kick time, and not the live staging register, is what gets applied. Varied spare-bit patterns in the rate register show that the code field is replaced on read while the other bits keep their written values.

// File: rtl/frac_ce_pkg.sv
package frac_ce_pkg;

    // Kick handshake states
    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_ARMED  = 2'd1,
        KS_SWITCH = 2'd2
    } kick_state_e;

endpackage

// File: rtl/frac_ce_accum.sv
module frac_ce_accum #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] active_n,
    output logic              ce,
    output logic              frame_pre
);
    localparam int FRAME = 1 << CODE_W;
    localparam logic [CODE_W-1:0] LAST_IDX = CODE_W'(FRAME - 1);
    localparam logic [CODE_W-1:0] PRE_IDX  = CODE_W'(FRAME - 2);

    logic [CODE_W-1:0] acc_q;
    logic [CODE_W-1:0] cnt_q;
    logic [CODE_W:0]   step;
    logic [CODE_W:0]   sum;
    logic              carry;
    logic              ce_q;

    always_comb begin
        step  = (CODE_W+1)'(FRAME) - {1'b0, active_n};
        sum   = {1'b0, acc_q} + step;
        carry = sum[CODE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
            ce_q  <= 1'b0;
        end else begin
            acc_q <= sum[CODE_W-1:0];
            cnt_q <= cnt_q + 1'b1;
            ce_q  <= carry;
        end
    end

    assign ce        = ce_q;
    assign frame_pre = (cnt_q == PRE_IDX);

    // Carries seen so far in the current frame
    logic [CODE_W:0] frame_pulses;
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_q == LAST_IDX) frame_pulses <= '0;
        else                             frame_pulses <= frame_pulses + (CODE_W+1)'(carry);
    end

    // R2: one frame holds exactly (32 - N) carries
    a_r2_frame_count: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST_IDX) |-> ((frame_pulses + (CODE_W+1)'(carry)) == step));

    // R1: a zero code yields an enable on every cycle
    a_r1_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (active_n == '0) |=> ce);

endmodule

// File: rtl/frac_ce_kick_fsm.sv
module frac_ce_kick_fsm
    import frac_ce_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kick_req,
    input  logic [CODE_W-1:0] staged_n,
    input  logic              frame_pre,
    output logic [CODE_W-1:0] active_n,
    output logic              kick_busy
);
    localparam int FRAME = 1 << CODE_W;
    localparam int BUSY_MAX = FRAME + 1;

    kick_state_e       state_q, state_d;
    logic [CODE_W-1:0] pend_n;
    logic [CODE_W-1:0] active_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_IDLE:   if (kick_req)  state_d = KS_ARMED;
            KS_ARMED:  if (frame_pre) state_d = KS_SWITCH;
            KS_SWITCH:                state_d = KS_IDLE;
            default:                  state_d = KS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    // Snapshot at kick, commit at frame edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_n   <= '0;
            active_q <= '0;
        end else begin
            if (state_q == KS_IDLE && kick_req) pend_n   <= staged_n;
            if (state_q == KS_SWITCH)           active_q <= pend_n;
        end
    end

    // Outputs
    always_comb begin
        kick_busy = (state_q != KS_IDLE);
        active_n  = active_q;
    end

    // Bound checker for the busy window
    logic [CODE_W+1:0] busy_cycles;
    always_ff @(posedge clk) begin
        if (!rst_n || !kick_busy) busy_cycles <= '0;
        else                      busy_cycles <= busy_cycles + 1'b1;
    end

    // R6: kick clears within the frame bound
    a_r6_kick_bound: assert property (@(posedge clk) disable iff (!rst_n)
        kick_busy |-> (busy_cycles < (CODE_W+2)'(BUSY_MAX)));

    // R7: active code only moves at the frame edge
    a_r7_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != KS_SWITCH) |=> $stable(active_n));

    // R8: snapshot untouched while a change is in flight
    a_r8_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != KS_IDLE) |=> $stable(pend_n));

    // R9: a pending kick is not dropped or restarted
    a_r9_armed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == KS_ARMED) |=> kick_busy);

endmodule

// File: rtl/frac_ce_regs.sv
module frac_ce_regs #(
    parameter int CODE_W    = 5,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int FIELD_LSB = 8,
    parameter int KICK_BIT  = 31,
    parameter int RATE_ADDR = 2,
    parameter int KICK_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic [CODE_W-1:0] active_n,
    input  logic              kick_busy,
    output logic [CODE_W-1:0] staged_n,
    output logic              kick_req,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] FIELD_MASK =
        ((DATA_W'(1) << CODE_W) - DATA_W'(1)) << FIELD_LSB;
    localparam logic [ADDR_W-1:0] RATE_A = ADDR_W'(RATE_ADDR);
    localparam logic [ADDR_W-1:0] KICK_A = ADDR_W'(KICK_ADDR);

    logic [DATA_W-1:0] rate_word;
    logic              rate_wr;

    assign rate_wr  = we && (addr == RATE_A);
    assign kick_req = we && (addr == KICK_A) && wdata[KICK_BIT];
    assign staged_n = rate_word[FIELD_LSB +: CODE_W];

    always_ff @(posedge clk) begin
        if (!rst_n)       rate_word <= '0;
        else if (rate_wr) rate_word <= wdata;
    end

    always_comb begin
        rdata = '0;
        if (addr == RATE_A)
            rdata = (rate_word & ~FIELD_MASK) | (DATA_W'(active_n) << FIELD_LSB);
        else if (addr == KICK_A)
            rdata[KICK_BIT] = kick_busy;
    end

    // R4: the staging word only moves on its own write
    a_r4_stage_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_wr |=> $stable(rate_word));

endmodule

// File: rtl/frac_ce_gen.sv
module frac_ce_gen #(
    parameter int CODE_W    = 5,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int FIELD_LSB = 8,
    parameter int KICK_BIT  = 31,
    parameter int RATE_ADDR = 2,
    parameter int KICK_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ce
);
    logic [CODE_W-1:0] staged_n;
    logic [CODE_W-1:0] active_n;
    logic              kick_req;
    logic              kick_busy;
    logic              frame_pre;

    frac_ce_regs #(
        .CODE_W(CODE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FIELD_LSB(FIELD_LSB), .KICK_BIT(KICK_BIT),
        .RATE_ADDR(RATE_ADDR), .KICK_ADDR(KICK_ADDR)
    ) i_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(reg_addr), .wdata(reg_wdata), .we(reg_we),
        .active_n(active_n), .kick_busy(kick_busy),
        .staged_n(staged_n), .kick_req(kick_req), .rdata(reg_rdata)
    );

    frac_ce_kick_fsm #(.CODE_W(CODE_W)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .kick_req(kick_req), .staged_n(staged_n), .frame_pre(frame_pre),
        .active_n(active_n), .kick_busy(kick_busy)
    );

    frac_ce_accum #(.CODE_W(CODE_W)) i_accum (
        .clk(clk), .rst_n(rst_n),
        .active_n(active_n), .ce(ce), .frame_pre(frame_pre)
    );

    // R5: an idle kick request is visible on the next cycle
    a_r5_kick_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_req && !kick_busy) |=> kick_busy);

endmodule

// File: tb/test_frac_ce_gen.sv
module test_frac_ce_gen;
    localparam logic [3:0] A_RATE = 4'd2;
    localparam logic [3:0] A_KICK = 4'd1;
    localparam int FRAME = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        ce;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frac_ce_gen i_frac_ce_gen (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .ce(ce)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Returns cycles since start_cyc when the kick bit reads 0
    task automatic wait_done(input int start_cyc, output int took);
        logic [31:0] v;
        for (int g = 0; g < 100; g++) begin
            do_read(A_KICK, v);
            if (!v[31]) break;
            @(negedge clk);
        end
        took = cyc - start_cyc;
    endtask

    // Count pulses over one frame, gaps over two frames
    task automatic measure(output int pulses, output int gmin, output int gmax);
        int last;
        last = -1; pulses = 0; gmin = 1000; gmax = 0;
        for (int i = 0; i < 2 * FRAME; i++) begin
            @(negedge clk);
            if (ce) begin
                if (i < FRAME) pulses++;
                if (last >= 0) begin
                    if (i - last < gmin) gmin = i - last;
                    if (i - last > gmax) gmax = i - last;
                end
                last = i;
            end
        end
    endtask

    task automatic kick_and_wait(output int took);
        int c0;
        do_write(A_KICK, 32'h8000_0000);
        c0 = cyc;
        wait_done(c0, took);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int p, gmin, gmax, took, oldn, n, step, lo, hi, c0;
        logic [31:0] spare;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        do_read(A_RATE, v);
        check(v == 32'h0, "R1 rate reg", v, 0);
        do_read(A_KICK, v);
        check(v == 32'h0, "R1 kick reg", v, 0);
        measure(p, gmin, gmax);
        check(p == FRAME, "R1 full rate", p, FRAME);

        // Sweep every code in scrambled order
        oldn = 0;
        for (int k = 1; k <= FRAME; k++) begin
            n = (k * 7) % FRAME;
            spare = (32'h5A3C_00C3 ^ (32'(k) << 17) ^ 32'(k)) & ~32'h0000_1F00;
            do_write(A_RATE, spare | (32'(n) << 8));
            do_read(A_RATE, v);
            check(v[12:8] == 5'(oldn), "R4 active field before kick", v[12:8], oldn);
            check((v & ~32'h1F00) == spare, "R10 spare bits", v & ~32'h1F00, spare);
            measure(p, gmin, gmax);
            check(p == FRAME - oldn, "R4 rate before kick", p, FRAME - oldn);
            do_write(A_KICK, 32'h8000_0000);
            c0 = cyc;
            do_read(A_KICK, v);
            check(v == 32'h8000_0000, "R5 kick reads 1", v, 32'h8000_0000);
            wait_done(c0, took);
            check(took <= FRAME + 1, "R6 completion bound", took, FRAME + 1);
            do_read(A_RATE, v);
            check(v[12:8] == 5'(n), "R6 new code read", v[12:8], n);
            repeat (3) @(negedge clk);
            measure(p, gmin, gmax);
            step = FRAME - n;
            check(p == step, "R2 pulses per frame", p, step);
            lo = FRAME / step;
            hi = (FRAME + step - 1) / step;
            if (step > 1) begin
                check(gmin >= lo, "R3 min gap", gmin, lo);
                check(gmax <= hi, "R3 max gap", gmax, hi);
            end else begin
                check(gmin == 1000 || gmin == FRAME, "R3 single pulse gap", gmin, FRAME);
            end
            oldn = n;
        end

        // R8: rewrite during pending kick
        do_write(A_RATE, 32'(5) << 8);
        do_write(A_KICK, 32'h8000_0000);
        c0 = cyc;
        do_write(A_RATE, 32'(9) << 8);
        wait_done(c0, took);
        do_read(A_RATE, v);
        check(v[12:8] == 5'd5, "R8 in-flight code kept", v[12:8], 5);
        repeat (3) @(negedge clk);
        measure(p, gmin, gmax);
        check(p == FRAME - 5, "R8 rate of in-flight code", p, FRAME - 5);
        kick_and_wait(took);
        do_read(A_RATE, v);
        check(v[12:8] == 5'd9, "R8 staged code on next kick", v[12:8], 9);

        // R7: rate constant across a frame right after completion
        repeat (3) @(negedge clk);
        measure(p, gmin, gmax);
        check(p == FRAME - 9, "R7 whole-frame rate", p, FRAME - 9);

        // R9: repeated kicks and bit-31-clear writes
        do_write(A_RATE, 32'(3) << 8);
        do_write(A_KICK, 32'h8000_0000);
        c0 = cyc;
        do_write(A_RATE, 32'(20) << 8);
        do_write(A_KICK, 32'h8000_0000);
        do_write(A_KICK, 32'h7FFF_FFFF);
        wait_done(c0, took);
        check(took <= FRAME + 1, "R9 bound from first kick", took, FRAME + 1);
        do_read(A_RATE, v);
        check(v[12:8] == 5'd3, "R9 first kick code", v[12:8], 3);
        do_write(A_KICK, 32'h7FFF_FFFF);
        do_read(A_KICK, v);
        check(v == 32'h0, "R9 clear-bit write ignored", v, 0);
        repeat (40) @(negedge clk);
        do_read(A_RATE, v);
        check(v[12:8] == 5'd3, "R9 no kick from clear-bit write", v[12:8], 3);

        // R10: unmapped address
        do_read(4'd7, v);
        check(v == 32'h0, "R10 unmapped read", v, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule